// File: doc/BRIEF.md
# Identifier-Matched CAN Message Object Store

This block sits behind a CAN receiver and decides whether an incoming standard-identifier frame belongs to a small set of dedicated identifiers. Each received frame carries a controller number, an 11-bit identifier, frame-format and remote flags, a data-length code and eight data bytes. The block compares it with a table of 16-bit entries. When the first enabled entry with the same controller number and identifier is found at index i, the frame is written into a three-word message object owned by that index. When no entry matches, a one-cycle pass pulse tells later filter stages to continue the search.

Each object carries a two-bit semaphore in its header word. The header is first written with the "writing" code, the two data words follow, and the header is then rewritten with the "fresh" code. Software reads objects through a registered read port and marks an object as consumed by clearing its semaphore. Table entries are loaded through a plain write port.

Top module: `can_fullobj_store`

## Requirements
- R1: A table entry is 16 bits: bits 15:13 controller number, bit 12 disable (1 = disabled, never hits), bit 11 unused, bits 10:0 identifier. After reset every entry is disabled.
- R2: A hit needs both the controller number and the identifier to equal an enabled entry; when several enabled entries match, the lowest index wins.
- R3: A frame accepted with no hit gives `pass_pulse` high for exactly the next cycle, does not raise `busy` and changes no object word.
- R4: A frame accepted with a hit gives `stored_pulse` high for the next cycle with `hit_idx` set to the matched index, and `busy` is high for exactly four cycles starting in that cycle.
- R5: The object of index i occupies word addresses 3i, 3i+1 and 3i+2 (byte offset 12i). Word 3i holds frame format in bit 31, remote flag in bit 30, semaphore in bits 25:24, data-length code zero-extended in bits 22:16 and identifier in bits 10:0; all other bits are 0.
- R6: Word 3i+1 holds data bytes 1..4 and word 3i+2 bytes 5..8, with the lower-numbered byte in the lower bits; byte 1 is `rx_data[7:0]`, byte 8 is `rx_data[63:56]`.
- R7: While an object is being written its semaphore reads 2'b01; once the write is finished it reads 2'b11.
- R8: A frame presented while `busy` is high is ignored: no pulse and no object change.
- R9: Asserting `cpu_clr` while idle sets the semaphore of object `cpu_clr_idx` to 2'b00 and keeps its other bits; a clear while `busy` is high has no effect.
- R10: `cpu_rd_data` shows the word at `cpu_rd_addr` one cycle after the address is sampled; addresses at or above 3×N_ENTRIES read 0.
- R11: After reset `busy`, `pass_pulse` and `stored_pulse` are 0 and every object word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | IDX_W | Table entry index |
| tbl_wdata | input | 16 | Table entry value |
| rx_valid | input | 1 | Received frame present |
| rx_ctrl | input | 3 | Source controller number |
| rx_id | input | 11 | Frame identifier |
| rx_ext | input | 1 | Frame-format flag |
| rx_rtr | input | 1 | Remote-request flag |
| rx_dlc | input | 4 | Data-length code |
| rx_data | input | 64 | Data bytes, byte 1 in bits 7:0 |
| cpu_rd_addr | input | WADDR_W | Object word address |
| cpu_rd_data | output | 32 | Registered read data |
| cpu_clr | input | 1 | Clear semaphore strobe |
| cpu_clr_idx | input | IDX_W | Object whose semaphore is cleared |
| busy | output | 1 | Object write in progress |
| pass_pulse | output | 1 | No entry matched |
| stored_pulse | output | 1 | Frame stored into an object |
| hit_idx | output | IDX_W | Index of the stored object |

## Verification
The assertions watch the handshake every cycle: the two pulses never coincide, a miss never raises busy, a store is always followed by a busy run of exactly four cycles, and no pulse appears while a write is in progress. What only the scenarios show is the content: lowest-index priority among duplicate entries, disabled entries being skipped, the exact header and data word layout, the 01 semaphore caught in mid-write, and a clear issued during a write leaving its target untouched.

// File: rtl/fcaf_pkg.sv
package fcaf_pkg;
    localparam int ID_W    = 11;
    localparam int CTRL_W  = 3;
    localparam int DLC_W   = 4;
    localparam int ENTRY_W = 16;
    localparam int WORD_W  = 32;
    localparam int DATA_W  = 64;

    localparam logic [1:0] SEM_READ  = 2'b00;
    localparam logic [1:0] SEM_WRITE = 2'b01;
    localparam logic [1:0] SEM_FRESH = 2'b11;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [ID_W-1:0]   id;
        logic              ext;
        logic              rtr;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_LOW,
        ST_HIGH,
        ST_SEAL
    } wr_state_e;

    function automatic logic [WORD_W-1:0] head_word(input frame_t f, input logic [1:0] sem);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31]    = f.ext;
        w[30]    = f.rtr;
        w[25:24] = sem;
        w[22:16] = {3'b000, f.dlc};
        w[10:0]  = f.id;
        return w;
    endfunction

    function automatic logic entry_off(input logic [ENTRY_W-1:0] e);
        return e[12];
    endfunction

    function automatic logic [CTRL_W-1:0] entry_ctrl(input logic [ENTRY_W-1:0] e);
        return e[15:13];
    endfunction

    function automatic logic [ID_W-1:0] entry_id(input logic [ENTRY_W-1:0] e);
        return e[10:0];
    endfunction
endpackage

// File: rtl/fcaf_lookup.sv
module fcaf_lookup
    import fcaf_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tbl_we,
    input  logic [IDX_W-1:0]    tbl_addr,
    input  logic [ENTRY_W-1:0]  tbl_wdata,
    input  logic [CTRL_W-1:0]   q_ctrl,
    input  logic [ID_W-1:0]     q_id,
    output logic                hit,
    output logic [IDX_W-1:0]    hit_idx
);
    localparam logic [ENTRY_W-1:0] ENTRY_RESET = 16'h1000;

    logic [ENTRY_W-1:0]   ent [N_ENTRIES];
    logic [N_ENTRIES-1:0] match;

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                ent[g] <= ENTRY_RESET;
            end else if (tbl_we && (int'(tbl_addr) == g)) begin
                ent[g] <= tbl_wdata;
            end
        end

        assign match[g] = !entry_off(ent[g])
                        && (entry_ctrl(ent[g]) == q_ctrl)
                        && (entry_id(ent[g]) == q_id);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/fcaf_writer.sv
module fcaf_writer
    import fcaf_pkg::*;
#(
    parameter int IDX_W   = 3,
    parameter int WADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic                hit,
    input  logic [IDX_W-1:0]    hit_idx_in,
    input  frame_t              frame,
    output logic                busy,
    output logic                pass_pulse,
    output logic                stored_pulse,
    output logic [IDX_W-1:0]    stored_idx,
    output logic                we,
    output logic [WADDR_W-1:0]  waddr,
    output logic [WORD_W-1:0]   wdata
);
    wr_state_e           state;
    frame_t              held;
    logic [WADDR_W-1:0]  base;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            held         <= '0;
            stored_idx   <= '0;
            pass_pulse   <= 1'b0;
            stored_pulse <= 1'b0;
        end else begin
            pass_pulse   <= 1'b0;
            stored_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            held         <= frame;
                            stored_idx   <= hit_idx_in;
                            stored_pulse <= 1'b1;
                            state        <= ST_HEAD;
                        end else begin
                            pass_pulse   <= 1'b1;
                        end
                    end
                end
                ST_HEAD: state <= ST_LOW;
                ST_LOW:  state <= ST_HIGH;
                ST_HIGH: state <= ST_SEAL;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign base = WADDR_W'(stored_idx) * WADDR_W'(3);

    always_comb begin
        we    = 1'b0;
        waddr = base;
        wdata = '0;
        case (state)
            ST_HEAD: begin
                we    = 1'b1;
                wdata = head_word(held, SEM_WRITE);
            end
            ST_LOW: begin
                we    = 1'b1;
                waddr = base + WADDR_W'(1);
                wdata = held.data[31:0];
            end
            ST_HIGH: begin
                we    = 1'b1;
                waddr = base + WADDR_W'(2);
                wdata = held.data[63:32];
            end
            ST_SEAL: begin
                we    = 1'b1;
                wdata = head_word(held, SEM_FRESH);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fcaf_objmem.sv
module fcaf_objmem
    import fcaf_pkg::*;
#(
    parameter int N_WORDS = 24,
    parameter int WADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [WADDR_W-1:0]  waddr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                clr_en,
    input  logic [WADDR_W-1:0]  clr_addr,
    input  logic [WADDR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]   rd_data
);
    logic [WORD_W-1:0] mem [N_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_WORDS; i++) begin
                mem[i] <= '0;
            end
            rd_data <= '0;
        end else begin
            if (we && (int'(waddr) < N_WORDS)) begin
                mem[waddr] <= wdata;
            end else if (clr_en && (int'(clr_addr) < N_WORDS)) begin
                mem[clr_addr][25:24] <= SEM_READ;
            end
            if (int'(rd_addr) < N_WORDS) begin
                rd_data <= mem[rd_addr];
            end else begin
                rd_data <= '0;
            end
        end
    end
endmodule

// File: rtl/can_fullobj_store.sv
module can_fullobj_store
    import fcaf_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int N_WORDS  = 3 * N_ENTRIES,
    localparam int WADDR_W  = $clog2(N_WORDS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tbl_we,
    input  logic [IDX_W-1:0]    tbl_addr,
    input  logic [ENTRY_W-1:0]  tbl_wdata,
    input  logic                rx_valid,
    input  logic [CTRL_W-1:0]   rx_ctrl,
    input  logic [ID_W-1:0]     rx_id,
    input  logic                rx_ext,
    input  logic                rx_rtr,
    input  logic [DLC_W-1:0]    rx_dlc,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic [WADDR_W-1:0]  cpu_rd_addr,
    output logic [WORD_W-1:0]   cpu_rd_data,
    input  logic                cpu_clr,
    input  logic [IDX_W-1:0]    cpu_clr_idx,
    output logic                busy,
    output logic                pass_pulse,
    output logic                stored_pulse,
    output logic [IDX_W-1:0]    hit_idx
);
    frame_t              frame;
    logic                lk_hit;
    logic [IDX_W-1:0]    lk_idx;
    logic                accept;
    logic                mem_we;
    logic [WADDR_W-1:0]  mem_waddr;
    logic [WORD_W-1:0]   mem_wdata;
    logic                clr_en;
    logic [WADDR_W-1:0]  clr_addr;

    assign frame  = '{ctrl: rx_ctrl, id: rx_id, ext: rx_ext, rtr: rx_rtr,
                      dlc: rx_dlc, data: rx_data};
    assign accept = rx_valid && !busy;
    assign clr_en = cpu_clr && !busy;
    assign clr_addr = WADDR_W'(cpu_clr_idx) * WADDR_W'(3);

    fcaf_lookup #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_lookup (
        .clk       (clk),
        .rst       (rst),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_wdata (tbl_wdata),
        .q_ctrl    (rx_ctrl),
        .q_id      (rx_id),
        .hit       (lk_hit),
        .hit_idx   (lk_idx)
    );

    fcaf_writer #(.IDX_W(IDX_W), .WADDR_W(WADDR_W)) u_writer (
        .clk          (clk),
        .rst          (rst),
        .accept       (accept),
        .hit          (lk_hit),
        .hit_idx_in   (lk_idx),
        .frame        (frame),
        .busy         (busy),
        .pass_pulse   (pass_pulse),
        .stored_pulse (stored_pulse),
        .stored_idx   (hit_idx),
        .we           (mem_we),
        .waddr        (mem_waddr),
        .wdata        (mem_wdata)
    );

    fcaf_objmem #(.N_WORDS(N_WORDS), .WADDR_W(WADDR_W)) u_mem (
        .clk      (clk),
        .rst      (rst),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wdata    (mem_wdata),
        .clr_en   (clr_en),
        .clr_addr (clr_addr),
        .rd_addr  (cpu_rd_addr),
        .rd_data  (cpu_rd_data)
    );
endmodule

// File: rtl/fcaf_checker.sv
module fcaf_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic pass_pulse,
    input logic stored_pulse
);
    assert_pulse_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(pass_pulse && stored_pulse));

    assert_miss_idle_R3: assert property (@(posedge clk) disable iff (rst)
        pass_pulse |-> !busy);

    assert_store_busy_R4: assert property (@(posedge clk) disable iff (rst)
        stored_pulse |-> busy);

    assert_busy_len_R4: assert property (@(posedge clk) disable iff (rst)
        stored_pulse |=> busy ##1 busy ##1 busy ##1 !busy);

    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> !(pass_pulse || stored_pulse));
endmodule

bind can_fullobj_store fcaf_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .pass_pulse   (pass_pulse),
    .stored_pulse (stored_pulse)
);

// File: tb/sim_can_fullobj_store.sv
module sim_can_fullobj_store;
    localparam int N   = 8;
    localparam int IW  = 3;
    localparam int NW  = 24;
    localparam int AW  = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_addr = '0;
    logic [15:0]   tbl_wdata = '0;
    logic          rx_valid = 1'b0;
    logic [2:0]    rx_ctrl = '0;
    logic [10:0]   rx_id = '0;
    logic          rx_ext = 1'b0;
    logic          rx_rtr = 1'b0;
    logic [3:0]    rx_dlc = '0;
    logic [63:0]   rx_data = '0;
    logic [AW-1:0] cpu_rd_addr = '0;
    logic [31:0]   cpu_rd_data;
    logic          cpu_clr = 1'b0;
    logic [IW-1:0] cpu_clr_idx = '0;
    logic          busy, pass_pulse, stored_pulse;
    logic [IW-1:0] hit_idx;

    can_fullobj_store #(.N_ENTRIES(N)) u0 (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    logic [15:0] tb_ent [N];
    logic [31:0] exp_w [NW];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int model_lookup(input logic [2:0] c, input logic [10:0] id);
        for (int i = 0; i < N; i++) begin
            if (!tb_ent[i][12] && tb_ent[i][15:13] == c && tb_ent[i][10:0] == id) return i;
        end
        return -1;
    endfunction

    always @(negedge clk) begin
        if (!rst && (pass_pulse || stored_pulse)) begin
            if (exp_q.size() == 0) begin
                chk("R8 unexpected pulse", {29'b0, pass_pulse, stored_pulse, 1'b0}, 32'h0);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e < 0)
                    chk("R3 miss pulse", {28'b0, pass_pulse, stored_pulse, 2'b0}, 32'h8);
                else
                    chk("R4 stored pulse/index", {28'b0, pass_pulse, stored_pulse, 2'b0} | 32'(hit_idx) << 8,
                        32'h4 | (32'(e) << 8));
            end
        end
    end

    task automatic prog(input int i, input logic [2:0] c, input logic dis, input logic [10:0] id);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = IW'(i); tbl_wdata = {c, dis, 1'b0, id};
        @(negedge clk);
        tbl_we = 1'b0;
        tb_ent[i] = {c, dis, 1'b0, id};
    endtask

    task automatic send(input logic [2:0] c, input logic [10:0] id, input logic ext,
                        input logic rtr, input logic [3:0] dlc, input logic [63:0] d);
        int e;
        e = model_lookup(c, id);
        exp_q.push_back(e);
        if (e >= 0) begin
            exp_w[3*e]   = {ext, rtr, 4'b0, 2'b11, 1'b0, 3'b0, dlc, 5'b0, id};
            exp_w[3*e+1] = d[31:0];
            exp_w[3*e+2] = d[63:32];
        end
        @(negedge clk);
        rx_valid = 1'b1; rx_ctrl = c; rx_id = id; rx_ext = ext; rx_rtr = rtr; rx_dlc = dlc; rx_data = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        cpu_rd_addr = AW'(a);
        @(negedge clk);
        v = cpu_rd_data;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        for (int i = 0; i < N; i++) tb_ent[i] = 16'h1000;
        for (int i = 0; i < NW; i++) exp_w[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 reset outputs", {29'b0, busy, pass_pulse, stored_pulse}, 32'h0);
        rd(4, v);
        chk("R11 reset object word", v, 32'h0);

        // R1: entries after reset are disabled, id 0 ctrl 0 must miss
        send(3'd0, 11'h000, 1'b0, 1'b0, 4'd0, 64'h0);
        @(negedge clk);

        prog(0, 3'd1, 1'b0, 11'h123);
        prog(1, 3'd1, 1'b0, 11'h123);
        prog(2, 3'd2, 1'b1, 11'h055);
        prog(3, 3'd2, 1'b0, 11'h055);
        prog(4, 3'd0, 1'b0, 11'h7FF);

        // R2: duplicate entries, lowest index wins
        send(3'd1, 11'h123, 1'b0, 1'b0, 4'd4, 64'h0000_0000_4433_2211);
        wait_idle();
        rd(0, v);
        chk("R5 header obj0", v, exp_w[0]);
        rd(1, v);
        chk("R6 low data obj0", v, 32'h4433_2211);

        // R1 disabled entry 2 skipped; R7 mid-write semaphore; R8/R9 during busy
        send(3'd2, 11'h055, 1'b0, 1'b0, 4'd8, 64'h8877_6655_4433_2211);
        cpu_rd_addr = AW'(9);
        rx_valid = 1'b1; rx_ctrl = 3'd1; rx_id = 11'h123;
        cpu_clr = 1'b1; cpu_clr_idx = 3'd0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 semaphore while writing", {30'b0, cpu_rd_data[25:24]}, 32'h1);
        chk("R4 busy during write", {31'b0, busy}, 32'h1);
        rx_valid = 1'b0; cpu_clr = 1'b0;
        wait_idle();
        rd(0, v);
        chk("R9 clear ignored while busy", v, exp_w[0]);
        rd(9, v);
        chk("R7 semaphore sealed", {30'b0, v[25:24]}, 32'h3);
        rd(11, v);
        chk("R6 high data obj3", v, 32'h8877_6655);

        // R2/R3: controller mismatch misses
        send(3'd0, 11'h123, 1'b0, 1'b0, 4'd1, 64'hFF);
        @(negedge clk);
        chk("R3 miss not busy", {31'b0, busy}, 32'h0);

        // R4: busy length; R5 flags in header
        send(3'd0, 11'h7FF, 1'b1, 1'b1, 4'd8, 64'hDEAD_BEEF_CAFE_F00D);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk("R4 busy cycles", 32'(n), 32'd4);
        rd(12, v);
        chk("R5 header obj4 flags", v, 32'hC308_07FF);

        // R9: clear while idle
        @(negedge clk);
        cpu_clr = 1'b1; cpu_clr_idx = 3'd0;
        @(negedge clk);
        cpu_clr = 1'b0;
        exp_w[0][25:24] = 2'b00;
        rd(0, v);
        chk("R9 clear while idle", v, exp_w[0]);

        // R1: disable entry 0, next match is index 1
        prog(0, 3'd1, 1'b1, 11'h123);
        send(3'd1, 11'h123, 1'b0, 1'b1, 4'd2, 64'h0000_0000_0000_BBAA);
        wait_idle();

        // R10: out-of-range read
        rd(NW, v);
        chk("R10 out of range read", v, 32'h0);

        // R3 R5 R6: full object memory compare
        for (int i = 0; i < NW; i++) begin
            rd(i, v);
            chk($sformatf("R5 word %0d", i), v, exp_w[i]);
        end
        repeat (2) @(negedge clk);
        chk("R8 pending expectations", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule